// File: doc/BRIEF.md
# Condition-Field Predicate Mask Selector

This block sits beside the condition register file and turns the wide read of every condition field into a narrow predicate mask. That mask can then travel on the broadcast bus to the function units. Each cycle that the read is enabled, the block receives one 32-bit word that holds eight 4-bit condition fields. It takes the same bit position from each field and so produces one predicate bit per field. The broadcast then carries 8 bits rather than 32.

Two controls shape the mask. A polarity flag complements the picked bits, which gives "execute when the condition is false" predication. A predication flag set low marks the operation as unpredicated. The block then drives all ones, so every lane executes and the consuming ALUs need no special case. The mask is registered, and a valid strobe marks the cycle in which it is new.

Top module: `cr_pred_select`

## Requirements
- R1: Condition field k occupies `cr_word[4k+3:4k]` (field 0 in bits 3:0, field 7 in bits 31:28). The bit picked from field k drives `pred_mask[k]`.
- R2: `bit_sel` (0..3) selects the bit position inside a field, and the same position is used for all eight fields. Value b picks `cr_word[4k+b]` for field k.
- R3: When `predicated` is 1 and `invert` is 1, each mask bit is the complement of the picked bit. When `invert` is 0, each mask bit equals the picked bit.
- R4: When `predicated` is 0, the captured mask is 8'hFF, whatever the values of `cr_word`, `bit_sel` and `invert`.
- R5: `pred_valid` is 1 in the cycle after a cycle in which `rd_en` was 1, and 0 in the cycle after a cycle in which `rd_en` was 0.
- R6: A mask is captured only on a clock edge where `rd_en` is 1. While `rd_en` is 0, `pred_mask` holds its value, however the other inputs change.
- R7: Reset is synchronous and active low. After a clock edge with `rst_n` at 0, `pred_mask` is 8'h00 and `pred_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_en | input | 1 | The condition word is valid this cycle; capture a mask |
| cr_word | input | 32 | All eight 4-bit condition fields, field 0 in the lowest bits |
| bit_sel | input | 2 | Bit position taken from every field |
| invert | input | 1 | Complement the picked bits |
| predicated | input | 1 | 1: use the picked bits; 0: force all ones |
| pred_mask | output | 8 | Registered predicate mask, one bit per field |
| pred_valid | output | 1 | The mask was captured on the previous edge |

## Verification
The path has a single register, so any wrong pick, polarity or override shows in `pred_mask` one cycle after the read that caused it. No fault is held back to show up later. A wrong field offset or a swapped bit index shows as a wrong bit only for words that have distinct bits in the affected positions. The bench therefore drives walking-one, walking-zero and pseudo-random words under every combination of select and flags. A capture that leaks through while the read is disabled shows on the very next edge as a changed mask, with `pred_valid` low.

// File: rtl/cr_pred_pkg.sv
// Package: shared defaults for the condition-field predicate selector.
// Assumes: condition fields are packed contiguously, lowest field in the lowest bits.
package cr_pred_pkg;
    localparam int unsigned CR_FIELDS_DFLT  = 8;
    localparam int unsigned CR_FIELD_W_DFLT = 4;

    // Polarity applied to the picked bits before the unpredicated override.
    typedef enum logic {
        POL_TRUE  = 1'b0,
        POL_FALSE = 1'b1
    } pred_pol_e;
endpackage

// File: rtl/cr_field_pick.sv
// Module: cr_field_pick
// Takes one bit position from every condition field of a packed word,
// giving one bit per field. Purely combinational.
// Assumes: FIELD_W is a power of two, so every value of sel names a real bit.
module cr_field_pick #(
    parameter int unsigned NF    = 8,
    parameter int unsigned FW    = 4,
    localparam int unsigned SELW = (FW > 1) ? $clog2(FW) : 1,
    localparam int unsigned WW   = NF * FW
) (
    input  logic [WW-1:0]   word_i,
    input  logic [SELW-1:0] sel_i,
    output logic [NF-1:0]   bits_o
);
    // One multiplexer per field, all driven by the shared select.
    for (genvar g = 0; g < NF; g++) begin : g_field
        logic [FW-1:0] fld;
        assign fld = word_i[g*FW +: FW];
        // Pick the selected position within this field.
        always_comb bits_o[g] = fld[sel_i];
    end
endmodule

// File: rtl/pred_polarity.sv
// Module: pred_polarity
// Applies the requested polarity to the picked bits, then replaces the
// result with all ones when the operation is unpredicated.
// Assumes: the override always wins over the polarity.
module pred_polarity
    import cr_pred_pkg::*;
#(
    parameter int unsigned NF = 8
) (
    input  logic [NF-1:0] bits_i,
    input  pred_pol_e     pol_i,
    input  logic          predicated_i,
    output logic [NF-1:0] mask_o
);
    logic [NF-1:0] polar;

    // Complement every picked bit for condition-false predication.
    always_comb polar = (pol_i == POL_FALSE) ? ~bits_i : bits_i;

    // Force every lane active when no predicate applies.
    always_comb mask_o = predicated_i ? polar : {NF{1'b1}};
endmodule

// File: rtl/pred_out_reg.sv
// Module: pred_out_reg
// Output stage: captures the mask on an enabled cycle and raises a
// one-cycle valid strobe behind the enable.
// Assumes: synchronous active-low reset; the mask holds between captures.
module pred_out_reg #(
    parameter int unsigned NF = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [NF-1:0] mask_i,
    output logic [NF-1:0] mask_o,
    output logic          valid_o
);
    // Mask register: clears on reset, loads only when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)      mask_o <= '0;
        else if (load_i) mask_o <= mask_i;
    end

    // Valid strobe: follows the load enable by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) valid_o <= 1'b0;
        else        valid_o <= load_i;
    end
endmodule

// File: rtl/cr_pred_select.sv
// Module: cr_pred_select (top)
// Reduces the wide read of all condition fields to a registered mask with
// one bit per field, ready for the predicate broadcast.
// Assumes: the caller holds cr_word, bit_sel, invert and predicated stable
// for the cycle in which rd_en is high.
module cr_pred_select
    import cr_pred_pkg::*;
#(
    parameter int unsigned NF    = CR_FIELDS_DFLT,
    parameter int unsigned FW    = CR_FIELD_W_DFLT,
    localparam int unsigned SELW = (FW > 1) ? $clog2(FW) : 1,
    localparam int unsigned WW   = NF * FW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd_en,
    input  logic [WW-1:0]   cr_word,
    input  logic [SELW-1:0] bit_sel,
    input  logic            invert,
    input  logic            predicated,
    output logic [NF-1:0]   pred_mask,
    output logic            pred_valid
);
    logic [NF-1:0] picked;
    logic [NF-1:0] shaped;
    pred_pol_e     pol;

    // Map the invert flag onto the polarity type.
    always_comb pol = invert ? POL_FALSE : POL_TRUE;

    cr_field_pick #(.NF(NF), .FW(FW)) i_pick (
        .word_i (cr_word),
        .sel_i  (bit_sel),
        .bits_o (picked)
    );

    pred_polarity #(.NF(NF)) i_pol (
        .bits_i       (picked),
        .pol_i        (pol),
        .predicated_i (predicated),
        .mask_o       (shaped)
    );

    pred_out_reg #(.NF(NF)) i_oreg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (rd_en),
        .mask_i  (shaped),
        .mask_o  (pred_mask),
        .valid_o (pred_valid)
    );
endmodule

// File: rtl/cr_pred_select_chk.sv
// Module: cr_pred_select_chk
// Checker bound to cr_pred_select. Relates the registered outputs to the
// inputs of the previous cycle.
module cr_pred_select_chk #(
    parameter int unsigned NF    = 8,
    parameter int unsigned FW    = 4,
    localparam int unsigned SELW = (FW > 1) ? $clog2(FW) : 1,
    localparam int unsigned WW   = NF * FW
) (
    input logic            clk,
    input logic            rst_n,
    input logic            rd_en,
    input logic [WW-1:0]   cr_word,
    input logic [SELW-1:0] bit_sel,
    input logic            invert,
    input logic            predicated,
    input logic [NF-1:0]   pred_mask,
    input logic            pred_valid
);
    // Expected mask for a predicated read, worked out by shifting.
    function automatic logic [NF-1:0] exp_mask(input logic [WW-1:0] w,
                                               input logic [SELW-1:0] s,
                                               input logic inv);
        logic [NF-1:0] r;
        for (int k = 0; k < NF; k++) begin
            r[k] = ((w >> (k*FW + int'(s))) & 1) != 0;
        end
        return inv ? ~r : r;
    endfunction

    // R5: the strobe follows the read enable
    a_r5_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> pred_valid);
    a_r5_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !pred_valid);
    // R4: an unpredicated read gives all ones
    a_r4_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !predicated) |=> (pred_mask == {NF{1'b1}}));
    // R1, R2, R3: a predicated read gives the selected bits with polarity
    a_r3_pick_polarity: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && predicated) |=>
        (pred_mask == exp_mask($past(cr_word), $past(bit_sel), $past(invert))));
    // R6: the mask holds while the read is disabled
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(pred_mask));
endmodule

bind cr_pred_select cr_pred_select_chk #(.NF(NF), .FW(FW)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (rd_en),
    .cr_word    (cr_word),
    .bit_sel    (bit_sel),
    .invert     (invert),
    .predicated (predicated),
    .pred_mask  (pred_mask),
    .pred_valid (pred_valid)
);

// File: tb/test_cr_pred_select.sv
// Bench: sweeps every select and flag combination over walking and
// pseudo-random condition words; expected masks are computed arithmetically.
module test_cr_pred_select;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] cr_word = '0;
    logic [1:0]  bit_sel = '0;
    logic        invert = 1'b0;
    logic        predicated = 1'b0;
    logic [7:0]  pred_mask;
    logic        pred_valid;

    int n_vec = 0;
    int n_bad = 0;
    logic done = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    cr_pred_select i_cr_pred_select (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .cr_word(cr_word),
        .bit_sel(bit_sel), .invert(invert), .predicated(predicated),
        .pred_mask(pred_mask), .pred_valid(pred_valid)
    );

    function automatic logic [7:0] model(input logic [31:0] w, input int s,
                                         input logic inv, input logic pr);
        logic [7:0] r;
        if (!pr) return 8'hFF;
        for (int k = 0; k < 8; k++) r[k] = ((w / (32'd1 << (4*k + s))) % 2) == 1;
        return inv ? ~r : r;
    endfunction

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Capture one vector, then check the hold behaviour on an idle cycle.
    task automatic apply(input logic [31:0] w, input int s, input logic inv,
                         input logic pr, input string req);
        logic [7:0] e;
        e = model(w, s, inv, pr);
        @(negedge clk);
        rd_en = 1'b1; cr_word = w; bit_sel = 2'(s); invert = inv; predicated = pr;
        @(negedge clk);
        check(req, {pred_valid, pred_mask}, {1'b1, e});
        rd_en = 1'b0; cr_word = ~w; bit_sel = 2'(s + 1); invert = ~inv; predicated = ~pr;
        @(negedge clk);
        check("R6/R5 hold", {pred_valid, pred_mask}, {1'b0, e});
    endtask

    initial begin
        logic [31:0] lfsr;
        repeat (2) @(negedge clk);
        check("R7 reset", {pred_valid, pred_mask}, 9'h000);
        rst_n = 1'b1;
        for (int s = 0; s < 4; s++) begin
            for (int f = 0; f < 4; f++) begin
                for (int b = 0; b < 32; b++) begin
                    apply(32'd1 << b, s, f[0], f[1], "R1/R2/R3/R4 walk1");
                    apply(~(32'd1 << b), s, f[0], f[1], "R1/R2/R3/R4 walk0");
                end
            end
        end
        lfsr = 32'hACE1_2468;
        for (int i = 0; i < 200; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            apply(lfsr, i % 4, lfsr[5], lfsr[9], "R2/R3 random");
            // R4: unpredicated override ignores polarity and word
            apply(lfsr, i % 4, 1'b1, 1'b0, "R4 override");
        end
        // Back-to-back reads: valid stays high (R5)
        @(negedge clk);
        rd_en = 1'b1; cr_word = 32'h0000_000F; bit_sel = 2'd0; invert = 1'b0; predicated = 1'b1;
        @(negedge clk);
        check("R5 first", {pred_valid, pred_mask}, {1'b1, 8'h01});
        cr_word = 32'hF000_0000; bit_sel = 2'd3;
        @(negedge clk);
        check("R1 back-to-back", {pred_valid, pred_mask}, {1'b1, 8'h80});
        // Reset mid-stream clears state (R7)
        rst_n = 1'b0;
        @(negedge clk);
        check("R7 reset again", {pred_valid, pred_mask}, 9'h000);
        rst_n = 1'b1; rd_en = 1'b0;
        @(negedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                n_vec++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule